// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands, each with a sign bit, an 8-bit biased exponent and a 23-bit fraction. It returns the packed 32-bit product together with five status flags. Operands are presented with a valid strobe and may be sent on every cycle. Each accepted operation comes out on a matching valid strobe after a fixed two-cycle latency.

The first stage decodes both operands and resolves the special cases: NaN, infinity and zero. In the same stage it sums the exponents and forms the full 48-bit product of the two 24-bit significands. The second stage normalises the product and rounds it under a selectable mode. It then folds exponent overflow into infinity and exponent underflow into a signed zero. Subnormal operands are read as zero, and results too small for the normal range are flushed to zero.

Top module: `fp32_mul`

## Requirements
- R1: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` high two clock edges later, carrying that operation's result and flags. Operations may be issued back to back.
- R2: For finite nonzero operands, the result sign is the XOR of the operand signs. The unrounded exponent is the sum of the biased exponents minus 127. The significand is the 48-bit product of the 24-bit significands, each with its leading one restored. When bit 47 of that product is set, the product is shifted right once and the exponent is incremented.
- R3: `rnd_mode` selects the rounding: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward zero, 2'b10 rounds toward plus infinity, and 2'b11 rounds toward minus infinity. The directed modes act on the magnitude according to the result sign.
- R4: When rounding carries out of the 24-bit significand, the fraction becomes zero and the exponent increases by one.
- R5: `flag_inexact` is set when any product bit below the kept 24 bits is nonzero, and also whenever overflow or underflow is reported.
- R6: A biased exponent of 255 or more after rounding returns a correctly signed infinity (exponent field all ones, fraction zero) in every rounding mode. It sets `flag_overflow` and `flag_inexact`.
- R7: A biased exponent of 0 or less after rounding returns a zero carrying the product sign. It sets `flag_underflow` and `flag_inexact`. A result with exponent 1 is kept.
- R8: A NaN operand, or zero times infinity, returns 32'h7FC00000 and sets `flag_invalid`. No other rounding flag is set.
- R9: Infinity times a nonzero finite operand returns an infinity with the XOR sign. An operand with a zero exponent field counts as zero, so its product with a finite value is a signed zero. Neither case sets a flag.
- R10: `flag_exception` is high exactly when overflow, underflow or invalid is high.
- R11: In reset, and on every cycle with `out_valid` low, `result` and all five flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| rnd_mode | input | 2 | Rounding mode select (see R3) |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Packed product |
| flag_underflow | output | 1 | Result flushed to zero |
| flag_overflow | output | 1 | Result saturated to infinity |
| flag_inexact | output | 1 | Result differs from the exact product |
| flag_exception | output | 1 | OR of overflow, underflow and invalid |
| flag_invalid | output | 1 | NaN operand or zero times infinity |

## Verification
Every result and flag is due two rising edges after its operands are sampled. The first edge loads the product stage and the second loads the output stage. Directed operations are driven on a falling edge, and the bench confirms that `out_valid` is still low one falling edge later and carries the expected values two falling edges later. Random back-to-back traffic is tracked through a two-entry queue of expected values, so the output on each falling edge is compared with the operation issued two cycles earlier, idle slots included.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_ZERO      = 2'b01,
        RND_UP        = 2'b10,
        RND_DOWN      = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic uf;
        logic of;
        logic inx;
        logic exc;
        logic inv;
    } fp_flags_t;

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output logic                  sign,
    output logic [EXP_W-1:0]      exp_f,
    output logic [FRAC_W:0]       sig,
    output logic                  is_zero,
    output logic                  is_inf,
    output logic                  is_nan
);
    logic exp_max;
    logic exp_min;
    logic frac_nz;

    always_comb begin
        sign    = op[EXP_W+FRAC_W];
        exp_f   = op[FRAC_W +: EXP_W];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |op[FRAC_W-1:0];
        // zero exponent field: value flushed, fraction dropped
        is_zero = exp_min;
        is_inf  = exp_max & ~frac_nz;
        is_nan  = exp_max & frac_nz;
        sig     = exp_min ? '0 : {1'b1, op[FRAC_W-1:0]};
    end

endmodule

// File: rtl/fpm_sig_mult.sv
module fpm_sig_mult #(
    parameter int SIG_W = 24
) (
    input  logic [SIG_W-1:0]   a,
    input  logic [SIG_W-1:0]   b,
    output logic [2*SIG_W-1:0] prod
);
    localparam int PROD_W = 2 * SIG_W;

    always_comb begin
        prod = PROD_W'(a) * PROD_W'(b);
    end

endmodule

// File: rtl/fpm_norm_round.sv
module fpm_norm_round
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    sign,
    input  logic [2*FRAC_W+1:0]     prod,
    input  logic [EXP_W+1:0]        exp_in,
    input  rnd_mode_e               mode,
    output logic [EXP_W+FRAC_W:0]   word,
    output logic                    uf,
    output logic                    of,
    output logic                    inx
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int EXPS_W = EXP_W + 2;
    localparam logic [EXPS_W-1:0] EMAX_U = EXPS_W'((1 << EXP_W) - 1);

    logic              top;
    logic [PROD_W-1:0] norm;
    logic [FRAC_W-1:0] frac;
    logic              g_bit;
    logic              r_bit;
    logic              s_bit;
    logic              lost;
    logic              inc;
    logic [SIG_W:0]    sum;
    logic              carry;
    logic [EXPS_W-1:0] exp_r;
    logic              neg;

    always_comb begin
        top   = prod[PROD_W-1];
        norm  = top ? prod : {prod[PROD_W-2:0], 1'b0};
        frac  = norm[PROD_W-2 -: FRAC_W];
        g_bit = norm[PROD_W-2-FRAC_W];
        r_bit = norm[PROD_W-3-FRAC_W];
        s_bit = |norm[PROD_W-4-FRAC_W:0];
        lost  = g_bit | r_bit | s_bit;

        unique case (mode)
            RND_NEAR_EVEN: inc = g_bit & (r_bit | s_bit | frac[0]);
            RND_ZERO:      inc = 1'b0;
            RND_UP:        inc = ~sign & lost;
            RND_DOWN:      inc = sign & lost;
            default:       inc = 1'b0;
        endcase

        sum   = {2'b01, frac} + {{SIG_W{1'b0}}, inc};
        carry = sum[SIG_W];
        exp_r = exp_in + EXPS_W'(top) + EXPS_W'(carry);
        neg   = exp_r[EXPS_W-1];

        of  = ~neg & (exp_r >= EMAX_U);
        uf  = neg | (exp_r == '0);
        inx = lost | of | uf;

        if (of) begin
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (uf) begin
            word = {sign, {(EXP_W+FRAC_W){1'b0}}};
        end else begin
            word = {sign, exp_r[EXP_W-1:0], sum[FRAC_W-1:0]};
        end
    end

endmodule

// File: rtl/fp32_mul.sv
module fp32_mul
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic [1:0]            rnd_mode,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] result,
    output logic                  flag_underflow,
    output logic                  flag_overflow,
    output logic                  flag_inexact,
    output logic                  flag_exception,
    output logic                  flag_invalid
);
    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int EXPS_W = EXP_W + 2;
    localparam logic [EXPS_W-1:0] BIAS_V = EXPS_W'((1 << (EXP_W - 1)) - 1);
    localparam logic [W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              valid;
        logic              sign;
        logic              special;
        logic              inv;
        logic [W-1:0]      spec_word;
        logic [PROD_W-1:0] prod;
        logic [EXPS_W-1:0] exp_sum;
        rnd_mode_e         mode;
    } s1_t;

    typedef struct packed {
        logic      valid;
        logic [W-1:0] word;
        fp_flags_t flags;
    } s2_t;

    // operand decode, one instance per operand
    logic [1:0][W-1:0]      ops;
    logic [1:0]             c_sign;
    logic [1:0][EXP_W-1:0]  c_exp;
    logic [1:0][SIG_W-1:0]  c_sig;
    logic [1:0]             c_zero;
    logic [1:0]             c_inf;
    logic [1:0]             c_nan;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
            .op      (ops[i]),
            .sign    (c_sign[i]),
            .exp_f   (c_exp[i]),
            .sig     (c_sig[i]),
            .is_zero (c_zero[i]),
            .is_inf  (c_inf[i]),
            .is_nan  (c_nan[i])
        );
    end

    logic [PROD_W-1:0] prod_w;

    fpm_sig_mult #(.SIG_W(SIG_W)) i_mult (
        .a    (c_sig[0]),
        .b    (c_sig[1]),
        .prod (prod_w)
    );

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;

    logic [W-1:0] rnd_word;
    logic         rnd_uf;
    logic         rnd_of;
    logic         rnd_inx;

    fpm_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_round (
        .sign   (s1_q.sign),
        .prod   (s1_q.prod),
        .exp_in (s1_q.exp_sum),
        .mode   (s1_q.mode),
        .word   (rnd_word),
        .uf     (rnd_uf),
        .of     (rnd_of),
        .inx    (rnd_inx)
    );

    logic res_sign;
    logic any_nan;
    logic zero_inf;
    logic any_inf;
    logic any_zero;

    always_comb begin
        res_sign = c_sign[0] ^ c_sign[1];
        any_nan  = |c_nan;
        zero_inf = (c_zero[0] & c_inf[1]) | (c_inf[0] & c_zero[1]);
        any_inf  = |c_inf;
        any_zero = |c_zero;

        // stage 1: decode, special cases, exponent sum, significand product
        s1_d       = '0;
        s1_d.valid = in_valid;
        if (in_valid) begin
            s1_d.sign    = res_sign;
            s1_d.mode    = rnd_mode_e'(rnd_mode);
            s1_d.prod    = prod_w;
            s1_d.exp_sum = EXPS_W'(c_exp[0]) + EXPS_W'(c_exp[1]) - BIAS_V;
            if (any_nan || zero_inf) begin
                s1_d.special   = 1'b1;
                s1_d.inv       = 1'b1;
                s1_d.spec_word = QNAN;
            end else if (any_inf) begin
                s1_d.special   = 1'b1;
                s1_d.spec_word = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end else if (any_zero) begin
                s1_d.special   = 1'b1;
                s1_d.spec_word = {res_sign, {(W-1){1'b0}}};
            end
        end

        // stage 2: normalise, round, range check
        s2_d       = '0;
        s2_d.valid = s1_q.valid;
        if (s1_q.valid) begin
            if (s1_q.special) begin
                s2_d.word      = s1_q.spec_word;
                s2_d.flags.inv = s1_q.inv;
                s2_d.flags.exc = s1_q.inv;
            end else begin
                s2_d.word      = rnd_word;
                s2_d.flags.uf  = rnd_uf;
                s2_d.flags.of  = rnd_of;
                s2_d.flags.inx = rnd_inx;
                s2_d.flags.exc = rnd_uf | rnd_of;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid      = s2_q.valid;
    assign result         = s2_q.word;
    assign flag_underflow = s2_q.flags.uf;
    assign flag_overflow  = s2_q.flags.of;
    assign flag_inexact   = s2_q.flags.inx;
    assign flag_exception = s2_q.flags.exc;
    assign flag_invalid   = s2_q.flags.inv;

endmodule

// File: rtl/fp32_mul_checker.sv
module fp32_mul_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  uf,
    input logic                  of,
    input logic                  inx,
    input logic                  exc,
    input logic                  inv
);
    localparam logic [EXP_W+FRAC_W:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [EXP_W+FRAC_W-1:0] INF_MAG =
        {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    // R1: two-edge latency from in_valid to out_valid
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R11: quiet outputs while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (result == '0 && {uf, of, inx, exc, inv} == 5'd0));

    // R6: overflow returns infinity and is inexact
    a_r6_overflow_inf: assert property (@(posedge clk) disable iff (!rst_n)
        of |-> (result[EXP_W+FRAC_W-1:0] == INF_MAG && inx));

    // R7: underflow returns signed zero and is inexact
    a_r7_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        uf |-> (result[EXP_W+FRAC_W-1:0] == '0 && inx));

    // R8: invalid returns the quiet NaN word
    a_r8_invalid_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        inv |-> (result == QNAN));

    // R10: exception summarises the three range and validity flags
    a_r10_exception_or: assert property (@(posedge clk) disable iff (!rst_n)
        exc == (of | uf | inv));

    // R6 R7 R8: at most one of the three conditions at a time
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({of, uf, inv}));

endmodule

bind fp32_mul fp32_mul_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_fp32_mul_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .result    (result),
    .uf        (flag_underflow),
    .of        (flag_overflow),
    .inx       (flag_inexact),
    .exc       (flag_exception),
    .inv       (flag_invalid)
);

// File: tb/test_fp32_mul.sv
`timescale 1ns/1ps
module test_fp32_mul;

    localparam int WD_CYCLES = 100000;
    localparam int N_RAND    = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_underflow, flag_overflow, flag_inexact, flag_exception, flag_invalid;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fp32_mul i_fp32_mul (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .op_a           (op_a),
        .op_b           (op_b),
        .rnd_mode       (rnd_mode),
        .out_valid      (out_valid),
        .result         (result),
        .flag_underflow (flag_underflow),
        .flag_overflow  (flag_overflow),
        .flag_inexact   (flag_inexact),
        .flag_exception (flag_exception),
        .flag_invalid   (flag_invalid)
    );

    // packed expectation: {word, uf, of, inx, exc, inv}
    function automatic logic [36:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] m);
        logic s, an, bn, ai, bi, az, bz, up, inx;
        int ea, eb, e, sh;
        longint unsigned p, q, rem, half;
        s  = a[31] ^ b[31];
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        an = (ea == 255) && (a[22:0] != 0);
        bn = (eb == 255) && (b[22:0] != 0);
        ai = (ea == 255) && (a[22:0] == 0);
        bi = (eb == 255) && (b[22:0] == 0);
        az = (ea == 0);
        bz = (eb == 0);
        if (an || bn || (az && bi) || (ai && bz)) return {32'h7FC00000, 5'b00011};
        if (ai || bi) return {s, 8'hFF, 23'd0, 5'b00000};
        if (az || bz) return {s, 31'd0, 5'b00000};
        p = {40'd0, 1'b1, a[22:0]} * {40'd0, 1'b1, b[22:0]};
        e = ea + eb - 127;
        if (p >= (64'd1 << 47)) begin
            sh = 24;
            e  = e + 1;
        end else begin
            sh = 23;
        end
        q    = p >> sh;
        rem  = p - (q << sh);
        half = 64'd1 << (sh - 1);
        inx  = (rem != 0);
        case (m)
            2'd0:    up = (rem > half) || ((rem == half) && q[0]);
            2'd1:    up = 1'b0;
            2'd2:    up = !s && inx;
            default: up = s && inx;
        endcase
        q = q + 64'(up);
        if (q == (64'd1 << 24)) begin
            q = q >> 1;
            e = e + 1;
        end
        if (e >= 255) return {s, 8'hFF, 23'd0, 5'b01110};
        if (e <= 0)   return {s, 31'd0, 5'b10110};
        return {s, e[7:0], q[22:0], 1'b0, 1'b0, inx, 1'b0, 1'b0};
    endfunction

    function automatic logic [36:0] got_vec();
        return {result, flag_underflow, flag_overflow, flag_inexact, flag_exception, flag_invalid};
    endfunction

    task automatic check_vec(input string tag, input logic exp_valid, input logic [36:0] exp_v);
        n_chk++;
        if (out_valid !== exp_valid || got_vec() !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b word=%08h flags(uf,of,inx,exc,inv)=%05b exp valid=%0b word=%08h flags=%05b",
                     tag, out_valid, result, got_vec()[4:0], exp_valid, exp_v[36:5], exp_v[4:0]);
        end
    endtask

    // one isolated operation with latency probes
    task automatic run_one(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic [1:0] m, input logic [36:0] exp_v);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; rnd_mode = m;
        @(negedge clk);
        in_valid = 1'b0; op_a = '0; op_b = '0;
        check_vec({"R1 one edge early: ", tag}, 1'b0, 37'd0);
        @(negedge clk);
        check_vec(tag, 1'b1, exp_v);
    endtask

    function automatic logic [31:0] rnd_op();
        logic [31:0] v;
        int k;
        k = int'($urandom % 16);
        if (k == 0) begin
            case ($urandom % 6)
                0:       v = 32'h00000000;
                1:       v = 32'h80000000;
                2:       v = 32'h7F800000;
                3:       v = 32'hFF800000;
                4:       v = 32'h7FC00000;
                default: v = 32'h00000005;
            endcase
        end else if (k < 3) begin
            v = $urandom;
        end else begin
            v[31]    = 1'($urandom % 2);
            v[30:23] = 8'(100 + ($urandom % 55));
            v[22:0]  = 23'($urandom);
        end
        return v;
    endfunction

    initial begin : watchdog
        #(WD_CYCLES * 5.0);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got no completion, exp finish within %0d cycles", WD_CYCLES);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [36:0] q0e, q1e;
        logic        q0v, q1v;
        logic [31:0] ra, rb;
        logic [1:0]  rm;
        logic        rv;
        void'($urandom(32'h5EED_0017));

        repeat (3) @(negedge clk);
        check_vec("R11 reset state", 1'b0, 37'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R11 idle after reset", 1'b0, 37'd0);

        // R2 exact products
        run_one("R2 1*1",    32'h3F800000, 32'h3F800000, 2'b00, {32'h3F800000, 5'b00000});
        run_one("R2 2*3",    32'h40000000, 32'h40400000, 2'b00, {32'h40C00000, 5'b00000});
        run_one("R2 -1.5*2", 32'hBFC00000, 32'h40000000, 2'b00, {32'hC0400000, 5'b00000});

        // R3 R5 rounding modes, discarded bits below half
        run_one("R3 near",   32'h3F800001, 32'h3F800001, 2'b00, {32'h3F800002, 5'b00100});
        run_one("R3 zero",   32'h3F800001, 32'h3F800001, 2'b01, {32'h3F800002, 5'b00100});
        run_one("R3 up",     32'h3F800001, 32'h3F800001, 2'b10, {32'h3F800003, 5'b00100});
        run_one("R3 down",   32'h3F800001, 32'h3F800001, 2'b11, {32'h3F800002, 5'b00100});
        run_one("R3 neg down", 32'hBF800001, 32'h3F800001, 2'b11, {32'hBF800003, 5'b00100});
        run_one("R3 neg up",   32'hBF800001, 32'h3F800001, 2'b10, {32'hBF800002, 5'b00100});
        // R3 ties
        run_one("R3 tie odd up",    32'h3F800001, 32'h3FC00000, 2'b00, {32'h3FC00002, 5'b00100});
        run_one("R3 tie zero",      32'h3F800001, 32'h3FC00000, 2'b01, {32'h3FC00001, 5'b00100});
        run_one("R3 tie even stay", 32'h3F800003, 32'h3FC00000, 2'b00, {32'h3FC00004, 5'b00100});
        run_one("R3 tie up mode",   32'h3F800003, 32'h3FC00000, 2'b10, {32'h3FC00005, 5'b00100});

        // R4 rounding carry into exponent: significands multiply to 2^47-1
        run_one("R4 carry near", 32'h3FCA6691, 32'h3FA1E58F, 2'b00, {32'h40000000, 5'b00100});
        run_one("R4 no carry zero", 32'h3FCA6691, 32'h3FA1E58F, 2'b01, {32'h3FFFFFFF, 5'b00100});

        // R6 overflow
        run_one("R6 overflow",     32'h7F000000, 32'h40000000, 2'b00, {32'h7F800000, 5'b01110});
        run_one("R6 neg overflow zero mode", 32'hFF000000, 32'h40000000, 2'b01, {32'hFF800000, 5'b01110});
        run_one("R6 largest exponent kept", 32'h7E800000, 32'h40000000, 2'b00, {32'h7F000000, 5'b00000});

        // R7 underflow
        run_one("R7 underflow",     32'h00800000, 32'h3F000000, 2'b00, {32'h00000000, 5'b10110});
        run_one("R7 neg underflow", 32'h80800000, 32'h3F000000, 2'b10, {32'h80000000, 5'b10110});
        run_one("R7 smallest normal kept", 32'h00800000, 32'h3F800000, 2'b00, {32'h00800000, 5'b00000});

        // R8 invalid
        run_one("R8 qnan operand", 32'h7FC00000, 32'h3F800000, 2'b00, {32'h7FC00000, 5'b00011});
        run_one("R8 zero*inf",     32'h00000000, 32'h7F800000, 2'b00, {32'h7FC00000, 5'b00011});
        run_one("R8 snan*inf",     32'h7F800001, 32'hFF800000, 2'b11, {32'h7FC00000, 5'b00011});
        run_one("R8 inf*-zero",    32'hFF800000, 32'h80000000, 2'b01, {32'h7FC00000, 5'b00011});

        // R9 infinity and zero operands
        run_one("R9 inf*-2",       32'h7F800000, 32'hC0000000, 2'b00, {32'hFF800000, 5'b00000});
        run_one("R9 subnormal*1",  32'h00000001, 32'h3F800000, 2'b00, {32'h00000000, 5'b00000});
        run_one("R9 -0*5",         32'h80000000, 32'h40A00000, 2'b00, {32'h80000000, 5'b00000});

        @(negedge clk);
        check_vec("R11 idle after directed", 1'b0, 37'd0);

        // R1 R2 R3 R5 R10 back-to-back random stream, two-deep expectation queue
        q0v = 1'b0; q1v = 1'b0; q0e = '0; q1e = '0;
        for (int i = 0; i < N_RAND + 2; i++) begin
            @(negedge clk);
            check_vec(q1v ? "R2 R3 R5 R10 random stream" : "R1 R11 random idle slot",
                      q1v, q1v ? q1e : 37'd0);
            q1v = q0v;
            q1e = q0e;
            rv = (i < N_RAND) && (($urandom % 4) != 0);
            ra = rnd_op();
            rb = rnd_op();
            rm = 2'($urandom);
            in_valid = rv; op_a = ra; op_b = rb; rnd_mode = rm;
            q0v = rv;
            q0e = rv ? ref_mul(ra, rb, rm) : 37'd0;
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule